// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32.768 kHz timebase, delivered as a one-cycle enable strobe in the system clock domain, into periodic interrupt events. A 15-bit prescaler counts strobes without stopping. A 4-bit rate code picks a power-of-two period, and an event fires on every strobe that brings the prescaler to a multiple of that period. Events therefore stay locked to the free-running count. They are not timed from the moment the divider was switched on.

Each event can produce two one-cycle pulses. The flag-set pulse is meant for the status logic that latches the periodic and summary interrupt flags and drives the interrupt line. The square-wave pulse goes to whatever consumes the square-wave output. Each pulse is gated by its own enable. The divider is active only while at least one of the two enables is set and the rate code is not zero.

Top module: `periodic_irq_divider`

## Requirements
- R1: While `rst_n` is low on a rising clock edge, the prescaler clears to zero and both outputs are low in the following cycle. After reset is released, rate code 3 with the flag enable set gives its first `pf_set` on the 4th strobe.
- R2: Rate code 0 produces no pulse on either output, whatever the enables are.
- R3: Rate codes 1 and 2 act as codes 8 and 9, so their periods are 128 and 256 strobes.
- R4: For rate codes 3 to 15, the period is 2^(code-1) strobes: 4 strobes for code 3, up to 16384 strobes for code 15.
- R5: A pulse fires on the strobe that brings the prescaler count (modulo 32768) to an exact multiple of the period. After an enable is set, the first pulse comes at the next such boundary, not one full period later.
- R6: With both enables low there are no pulses, but the prescaler keeps counting strobes.
- R7: `pf_set` pulses only when `pie_en` is high at the strobe. `sqw_pulse` pulses only when `sqw_en` is high at the strobe.
- R8: A pulse appears in the clock cycle right after the strobe edge and lasts exactly one cycle. Cycles without a strobe never carry a pulse.
- R9: A change of rate code or enables takes effect at the next strobe, with no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle strobe at the 32.768 kHz timebase rate |
| rate_code | input | 4 | Period select; 0 = off |
| pie_en | input | 1 | Enables the flag-set pulse |
| sqw_en | input | 1 | Enables the square-wave pulse |
| pf_set | output | 1 | One-cycle pulse that sets the periodic and summary flags |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
A wrong prescaler value shows up as a pulse at the wrong strobe. It can be seen at the very next period boundary, which is at most 4 strobes away for code 3 and as far as 16384 strobes away for code 15. The bench therefore runs the longest codes for two full periods. A wrong period mask or a wrong code alias shows up as a wrong strobe count between consecutive pulses. A gating fault shows up in the first cycle after a strobe as a missing pulse or a pulse on the wrong output. The behavioural model is compared with the design on every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/periodic_irq_divider_pkg.sv
// Shared definitions for the periodic interrupt divider.
// Assumes rate codes are unsigned and that aliasing applies to the low codes.
package periodic_irq_divider_pkg;

    // Enable pair carried between the top and the pulse generator
    typedef struct packed {
        logic pie;
        logic sqw;
    } pid_en_t;

    // Lowest rate codes are folded upward by this amount
    localparam int unsigned PID_ALIAS_MAX = 2;
    localparam int unsigned PID_ALIAS_ADD = 7;

    // Returns log2 of the period for a nonzero code (0 when code is 0)
    function automatic int unsigned pid_shift(input int unsigned code);
        int unsigned eff;
        if (code == 0) begin
            return 0;
        end
        eff = (code <= PID_ALIAS_MAX) ? code + PID_ALIAS_ADD : code;
        return eff - 1;
    endfunction

endpackage

// File: rtl/pid_prescaler.sv
// Free-running strobe counter.
// Advances by one on each timebase strobe and wraps at 2^W.
// Assumes the strobe is a single-cycle enable in the clk domain.
module pid_prescaler #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);

    // Value the counter will hold after the current strobe
    always_comb begin
        cnt_nxt = cnt_q + W'(1);
    end

    // Count register, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/pid_rate_decode.sv
// Decodes the rate code into a boundary mask and an active flag.
// mask has the low (shift) bits set; a count is on a boundary when count & mask == 0.
// Assumes the period never exceeds the prescaler range.
module pid_rate_decode
    import periodic_irq_divider_pkg::*;
#(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned W      = 15
) (
    input  logic [CODE_W-1:0] code,
    output logic [W-1:0]      mask,
    output logic              code_on
);

    localparam int unsigned SHIFT_W = $clog2(W + 1);

    logic [SHIFT_W-1:0] shift;

    // Effective log2 period after aliasing
    always_comb begin
        shift   = SHIFT_W'(pid_shift(int'(code)));
        code_on = (code != '0);
    end

    // One mask bit per prescaler bit
    for (genvar i = 0; i < int'(W); i++) begin : g_mask
        assign mask[i] = (int'(shift) > i);
    end

endmodule

// File: rtl/pid_pulse_gen.sv
// Produces the registered one-cycle flag-set and square-wave pulses.
// Fires when a strobe lands the prescaler on a period boundary while the
// divider is active. Assumes cnt_nxt is the post-strobe prescaler value.
module pid_pulse_gen
    import periodic_irq_divider_pkg::*;
#(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] mask,
    input  logic         code_on,
    input  pid_en_t      en,
    output logic         pf_q,
    output logic         sq_q
);

    logic boundary;
    logic fire;

    // Boundary test and activity gating
    always_comb begin
        boundary = ((cnt_nxt & mask) == '0);
        fire     = strobe && boundary && code_on && (en.pie || en.sqw);
    end

    // Pulse registers, low unless the current cycle fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            sq_q <= 1'b0;
        end else begin
            pf_q <= fire && en.pie;
            sq_q <= fire && en.sqw;
        end
    end

endmodule

// File: rtl/periodic_irq_divider.sv
// Top of the periodic interrupt divider.
// Counts timebase strobes, decodes the rate code and emits aligned pulses.
// Assumes tick_en is a single-cycle strobe synchronous to clk.
module periodic_irq_divider
    import periodic_irq_divider_pkg::*;
#(
    parameter int unsigned PRESC_W = 15,
    parameter int unsigned CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqw_en,
    output logic              pf_set,
    output logic              sqw_pulse
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] presc_nxt;
    logic [PRESC_W-1:0] bnd_mask;
    logic               code_on;
    pid_en_t            en;

    // Bundle the enables
    always_comb begin
        en.pie = pie_en;
        en.sqw = sqw_en;
    end

    pid_prescaler #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (tick_en),
        .cnt_q   (presc_q),
        .cnt_nxt (presc_nxt)
    );

    pid_rate_decode #(.CODE_W(CODE_W), .W(PRESC_W)) u_dec (
        .code    (rate_code),
        .mask    (bnd_mask),
        .code_on (code_on)
    );

    pid_pulse_gen #(.W(PRESC_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (tick_en),
        .cnt_nxt (presc_nxt),
        .mask    (bnd_mask),
        .code_on (code_on),
        .en      (en),
        .pf_q    (pf_set),
        .sq_q    (sqw_pulse)
    );

endmodule

// File: rtl/periodic_irq_divider_chk.sv
// Property checker for the periodic interrupt divider, bound to the top.
// Assumes the shortest period is 4 strobes.
module periodic_irq_divider_chk #(
    parameter int unsigned PRESC_W = 15,
    parameter int unsigned CODE_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic [CODE_W-1:0]  rate_code,
    input logic               pie_en,
    input logic               sqw_en,
    input logic               pf_set,
    input logic               sqw_pulse,
    input logic [PRESC_W-1:0] presc
);

    // R8
    pf_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |=> !pf_set);

    // R8
    pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_set || sqw_pulse) |-> $past(tick_en));

    // R7
    pf_needs_pie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |-> $past(pie_en));

    // R7
    sq_needs_sqw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> $past(sqw_en));

    // R2
    code_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_set || sqw_pulse) |-> ($past(rate_code) != '0));

    // R5
    pulse_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_set || sqw_pulse) |-> (presc[1:0] == 2'b00));

endmodule

bind periodic_irq_divider periodic_irq_divider_chk #(
    .PRESC_W (PRESC_W),
    .CODE_W  (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .pf_set    (pf_set),
    .sqw_pulse (sqw_pulse),
    .presc     (presc_q)
);

// File: tb/periodic_irq_divider_tb.sv
module periodic_irq_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    wire        pf_set;
    wire        sqw_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    periodic_irq_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .pf_set    (pf_set),
        .sqw_pulse (sqw_pulse)
    );

    function automatic int ref_period(input int c);
        int e;
        if (c == 0) return 0;
        e = (c <= 2) ? c + 7 : c;
        return 1 << (e - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: strobe count and the expected pulses
    int m_cnt = 0;
    int m_per;
    bit m_tk;
    bit e_pf = 1'b0;
    bit e_sq = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            e_pf <= 1'b0;
            e_sq <= 1'b0;
        end else if (tick_en) begin
            m_cnt = (m_cnt + 1) % 32768;
            m_per = ref_period(int'(rate_code));
            m_tk  = (m_per != 0) && (pie_en || sqw_en) && (m_cnt % m_per == 0);
            e_pf <= m_tk && pie_en;
            e_sq <= m_tk && sqw_en;
        end else begin
            e_pf <= 1'b0;
            e_sq <= 1'b0;
        end
    end

    // Strobes since the last pulse, counted at the edge they are used
    int gap = 0;
    int last_iv = 0;
    int n_pf = 0;
    int n_sq = 0;
    always @(posedge clk) begin
        if (!rst_n) gap = 0;
        else if (tick_en) gap++;
    end

    // Per-cycle comparison and pulse bookkeeping
    always @(negedge clk) begin
        check(pf_set === e_pf, "R5 pf_set vs model", int'(pf_set), int'(e_pf));
        check(sqw_pulse === e_sq, "R5 sqw_pulse vs model", int'(sqw_pulse), int'(e_sq));
        if (pf_set) n_pf++;
        if (sqw_pulse) n_sq++;
        if (pf_set || sqw_pulse) begin
            last_iv = gap;
            gap = 0;
        end
    end

    task automatic strobe_once(output bit p, output bit s);
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        p = pf_set;
        s = sqw_pulse;
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(input int code, input bit pie, input bit sq, input string req);
        int per;
        int p0;
        int s0;
        per = ref_period(code);
        @(negedge clk);
        rate_code = 4'(code);
        pie_en = pie;
        sqw_en = sq;
        p0 = n_pf;
        s0 = n_sq;
        tick_en = 1'b1;
        repeat (2 * per + 2) @(negedge clk);
        tick_en = 1'b0;
        check(last_iv == per, req, last_iv, per);
        if (pie) check((n_pf - p0) >= 2, req, n_pf - p0, 2);
        if (sq) check((n_sq - s0) >= 2, req, n_sq - s0, 2);
    endtask

    initial begin
        bit p;
        bit s;
        int p0;
        int s0;

        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        check(pf_set == 1'b0 && sqw_pulse == 1'b0, "R1 outputs in reset",
              int'(pf_set | sqw_pulse), 0);
        rst_n = 1'b1;

        // R1: first pulse on the 4th strobe for code 3
        rate_code = 4'd3;
        pie_en = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            strobe_once(p, s);
            check(p == (i == 4), "R1 first pulse after reset", int'(p), int'(i == 4));
        end

        // R8: pulse lasts one cycle, none without strobe
        @(negedge clk);
        check(pf_set == 1'b0, "R8 pulse width", int'(pf_set), 0);
        repeat (4) @(negedge clk);
        check(pf_set == 1'b0, "R8 no strobe no pulse", int'(pf_set), 0);

        // R9: count is 4; switch to code 4, boundary at 8
        rate_code = 4'd4;
        for (int i = 5; i <= 8; i++) begin
            strobe_once(p, s);
            check(p == (i == 8), "R9 code change", int'(p), int'(i == 8));
        end

        // R6 and R5: idle divider keeps counting, alignment holds
        do_reset();
        rate_code = 4'd4;
        pie_en = 1'b0;
        sqw_en = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            strobe_once(p, s);
            check(p == 1'b0 && s == 1'b0, "R6 idle no pulse", int'(p | s), 0);
        end
        pie_en = 1'b1;
        for (int i = 11; i <= 16; i++) begin
            strobe_once(p, s);
            check(p == (i == 16), "R5 aligned first pulse", int'(p), int'(i == 16));
        end

        // R2: code 0 silent with both enables
        @(negedge clk);
        rate_code = 4'd0;
        pie_en = 1'b1;
        sqw_en = 1'b1;
        p0 = n_pf;
        s0 = n_sq;
        tick_en = 1'b1;
        repeat (600) @(negedge clk);
        tick_en = 1'b0;
        check((n_pf - p0) == 0 && (n_sq - s0) == 0, "R2 code 0 silent",
              (n_pf - p0) + (n_sq - s0), 0);

        // R7: each pulse follows only its own enable
        p0 = n_pf;
        measure(5, 1'b0, 1'b1, "R7 sqw only period");
        check(n_pf == p0, "R7 no pf without pie", n_pf - p0, 0);
        s0 = n_sq;
        measure(5, 1'b1, 1'b0, "R7 pie only period");
        check(n_sq == s0, "R7 no sqw without sqw_en", n_sq - s0, 0);

        // R3: aliased low codes
        measure(1, 1'b1, 1'b1, "R3 code 1 period");
        measure(2, 1'b1, 1'b0, "R3 code 2 period");

        // R4: every direct code
        for (int c = 3; c <= 15; c++) begin
            measure(c, 1'b1, c[0], "R4 period");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule